// File: doc/BRIEF.md
# Grouped Carry-Select Adder with Increment Converter

This block is a purely combinational adder meant for the summation stages of a wide multiplier. It adds two operands and a carry-in and returns a sum of the same width plus a carry-out. The operand is cut into groups. The lowest group is a plain ripple adder fed by the external carry-in.

Every higher group does its addition once, with an assumed carry-in of zero. It then forms the carry-in-one answer from that first result with an increment converter instead of a second adder. The converter flips each bit from the bottom up to and including the first zero it meets. The true carry leaving the group below then picks one of the two answers.

Group sizes come from an elaboration-time choice. In the growing mode, widths rise by one per group toward the MSB, with the two lowest groups equal, so the later carries arrive about when the wider groups finish. In the uniform mode, every group has the base width. The top group always takes whatever bits are left. The operand width and the base group width are parameters.

Top module: `csa_bec_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `opd_a + opd_b + carry_in` computed at WIDTH+1 bits, for every operand value, at WIDTH 8 (all inputs) and at WIDTH 32.
- R2: With the operands held, raising `carry_in` from 0 to 1 increases the (WIDTH+1)-bit result `{carry_out, sum_out}` by exactly one.
- R3: When `opd_a + opd_b` is all ones and `carry_in` is 1, the carry ripples through every group: `sum_out` is zero and `carry_out` is 1.
- R4: With both operands zero and `carry_in` 0, `sum_out` is zero and `carry_out` is 0.
- R5: Swapping `opd_a` and `opd_b` does not change `sum_out` or `carry_out`.
- R6: A carry produced at any bit k (operand a = 2^k − 1, operand b = 1) reaches bit k correctly, including across every group boundary. The result is sum = 2^k, or carry_out = 1 and sum = 0 when k = WIDTH.
- R7: When both operand MSBs are 1, `carry_out` is 1.
- R8: The uniform sizing mode and the growing sizing mode give identical results for identical inputs, including widths where the top group is narrower than the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First addend |
| opd_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the MSB |

## Verification
The two functions that can act in the same evaluation are the increment converter's full inversion and the group select. This happens when a group's zero-carry sum is all ones and the group below delivers a carry, so the group must pass a carry onward through its all-ones term while its sum bits wrap to zero. The case is forced with operand pairs whose sum is all ones plus a carry-in, and with a = 2^k − 1, b = 1 for every k, which lands the carry on every group edge. Each result is judged against a behavioural addition computed in the bench. The 8-bit builds in both sizing modes are also swept over every input combination.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef enum logic {
        SIZE_UNIFORM = 1'b0,
        SIZE_GROWING = 1'b1
    } sizing_e;

    // Nominal width of group idx before clamping to the operand width.
    function automatic int nominal_w(int base, sizing_e mode, int idx);
        int w;
        if (mode == SIZE_UNIFORM || idx == 0) w = base;
        else                                  w = base + idx - 1;
        if (w < 1) w = 1;
        return w;
    endfunction

    function automatic int min_int(int x, int y);
        return (x < y) ? x : y;
    endfunction

    // Number of groups needed to cover width bits.
    function automatic int group_count(int width, int base, sizing_e mode);
        int left;
        int n;
        left = width;
        n    = 0;
        while (left > 0) begin
            left = left - min_int(nominal_w(base, mode, n), left);
            n    = n + 1;
        end
        return n;
    endfunction

    // Lowest bit position of group idx.
    function automatic int group_lsb(int width, int base, sizing_e mode, int idx);
        int pos;
        pos = 0;
        for (int k = 0; k < idx; k++) begin
            pos = pos + min_int(nominal_w(base, mode, k), width - pos);
        end
        return pos;
    endfunction

    // Actual width of group idx after clamping.
    function automatic int group_width(int width, int base, sizing_e mode, int idx);
        return min_int(nominal_w(base, mode, idx), width - group_lsb(width, base, mode, idx));
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < W; i++) begin
            sum[i] = a[i] ^ b[i] ^ c;
            c      = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
        end
        cout = c;
    end
endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         all_ones
);
    // Bit i flips while every bit below it is one: the flip stops after
    // the first zero found from the LSB upward.
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < W; i++) begin
            dout[i] = din[i] ^ run;
            run     = run & din[i];
        end
        all_ones = run;
    end
endmodule

// File: rtl/csa_sel_group.sv
module csa_sel_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] sum_c0;
    logic         co_c0;
    logic [W-1:0] sum_c1;
    logic         full_c0;

    csa_ripple #(.W(W)) u_add (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (sum_c0),
        .cout (co_c0)
    );

    csa_excess1 #(.W(W)) u_inc (
        .din      (sum_c0),
        .dout     (sum_c1),
        .all_ones (full_c0)
    );

    always_comb begin
        if (sel_cin) begin
            sum  = sum_c1;
            cout = co_c0 | full_c0;
        end else begin
            sum  = sum_c0;
            cout = co_c0;
        end
    end
endmodule

// File: rtl/csa_bec_adder.sv
module csa_bec_adder #(
    parameter int               WIDTH  = 32,
    parameter int               BASE_W = 2,
    parameter csa_pkg::sizing_e SIZING = csa_pkg::SIZE_GROWING
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    localparam int NGRP = csa_pkg::group_count(WIDTH, BASE_W, SIZING);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LSB = csa_pkg::group_lsb(WIDTH, BASE_W, SIZING, g);
        localparam int GW  = csa_pkg::group_width(WIDTH, BASE_W, SIZING, g);
        logic          co;
        logic [GW-1:0] s;

        if (g == 0) begin : g_low
            csa_ripple #(.W(GW)) u_low (
                .a    (opd_a[LSB +: GW]),
                .b    (opd_b[LSB +: GW]),
                .cin  (carry_in),
                .sum  (s),
                .cout (co)
            );
        end else begin : g_up
            csa_sel_group #(.W(GW)) u_up (
                .a       (opd_a[LSB +: GW]),
                .b       (opd_b[LSB +: GW]),
                .sel_cin (g_grp[g-1].co),
                .sum     (s),
                .cout    (co)
            );
        end

        assign sum_out[LSB +: GW] = s;
    end

    assign carry_out = g_grp[NGRP-1].co;
endmodule

// File: rtl/csa_bec_adder_chk.sv
module csa_bec_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opd_a,
    input logic [WIDTH-1:0] opd_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out
);
    logic [WIDTH:0] ref_sum;
    logic [WIDTH:0] ref_nc;

    always_comb begin
        ref_nc  = {1'b0, opd_a} + {1'b0, opd_b};
        ref_sum = ref_nc + {{WIDTH{1'b0}}, carry_in};
    end

    always_comb begin
        p_sum_matches_r1: assert ({carry_out, sum_out} == ref_sum)
            else $error("R1 sum mismatch");
        p_full_ripple_r3: assert (!(ref_nc == {1'b0, {WIDTH{1'b1}}} && carry_in)
                                  || (carry_out && sum_out == '0))
            else $error("R3 full ripple wrong");
        p_zero_in_r4: assert (!(opd_a == '0 && opd_b == '0 && !carry_in)
                              || (sum_out == '0 && !carry_out))
            else $error("R4 zero case wrong");
        p_msb_carry_r7: assert (!(opd_a[WIDTH-1] && opd_b[WIDTH-1]) || carry_out)
            else $error("R7 msb carry missing");
    end
endmodule

bind csa_bec_adder csa_bec_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
);

// File: tb/sim_csa_bec_adder.sv
`timescale 1ns/1ps
module sim_csa_bec_adder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [7:0]  a8, b8, s8g, s8u;
    logic        c8, co8g, co8u;

    csa_bec_adder #(.WIDTH(32), .BASE_W(2), .SIZING(csa_pkg::SIZE_GROWING)) u0 (
        .opd_a(a32), .opd_b(b32), .carry_in(c32), .sum_out(s32), .carry_out(co32));
    csa_bec_adder #(.WIDTH(8), .BASE_W(2), .SIZING(csa_pkg::SIZE_GROWING)) u8g (
        .opd_a(a8), .opd_b(b8), .carry_in(c8), .sum_out(s8g), .carry_out(co8g));
    csa_bec_adder #(.WIDTH(8), .BASE_W(3), .SIZING(csa_pkg::SIZE_UNIFORM)) u8u (
        .opd_a(a8), .opd_b(b8), .carry_in(c8), .sum_out(s8u), .carry_out(co8u));

    localparam int NV = 10;
    localparam logic [31:0] VA [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000,
        32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'h5555_5555, 32'h7FFF_FFFF,
        32'hF0F0_F0F0, 32'h0000_0003};
    localparam logic [31:0] VB [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h8000_0000,
        32'h8765_4321, 32'h1111_1111, 32'h0000_0001, 32'hAAAA_AAAA, 32'h0000_0001,
        32'h0F0F_0F0F, 32'h0000_0001};
    localparam logic VC [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    task automatic check(input bit ok, input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive32(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        a32 = a; b32 = b; c32 = c;
        #1;
    endtask

    function automatic logic [32:0] ref32(logic [31:0] a, logic [31:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {32'd0, c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 33'd0, 33'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [32:0] r0, r1, exp;
        logic [31:0] x, y;
        a32 = '0; b32 = '0; c32 = 1'b0; a8 = '0; b8 = '0; c8 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R4: zero inputs during reset give zero outputs
        check({co32, s32} == 33'd0, "R4", {co32, s32}, 33'd0);
        check({co8g, s8g} == 9'd0 && {co8u, s8u} == 9'd0, "R4",
              {24'd0, co8g, s8g}, 33'd0);
        rst = 1'b0;

        // R1: vector table
        for (int i = 0; i < NV; i++) begin
            drive32(VA[i], VB[i], VC[i]);
            exp = ref32(VA[i], VB[i], VC[i]);
            check({co32, s32} == exp, "R1", {co32, s32}, exp);
        end

        // R3: all-ones sums plus carry-in ripple through every group
        drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
        check({co32, s32} == 33'h1_0000_0000, "R3", {co32, s32}, 33'h1_0000_0000);
        drive32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        check({co32, s32} == 33'h1_0000_0000, "R3", {co32, s32}, 33'h1_0000_0000);

        // R6: carry generated at every bit position k
        for (int k = 1; k <= 32; k++) begin
            x = (k == 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
            drive32(x, 32'd1, 1'b0);
            exp = 33'd1 << k;
            check({co32, s32} == exp, "R6", {co32, s32}, exp);
        end

        // R7: both MSBs set
        drive32(32'h8000_0001, 32'h8000_0000, 1'b0);
        check(co32 == 1'b1, "R7", {32'd0, co32}, 33'd1);

        // R1/R2/R5 at 32 bits with pseudo-random operands
        x = 32'h1357_9BDF; y = 32'h2468_ACE0;
        for (int n = 0; n < 400; n++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            y = (y ^ (y << 13)); y = y ^ (y >> 17); y = y ^ (y << 5);
            drive32(x, y, n[0]);
            exp = ref32(x, y, n[0]);
            check({co32, s32} == exp, "R1", {co32, s32}, exp);
            drive32(x, y, 1'b0); r0 = {co32, s32};
            drive32(x, y, 1'b1); r1 = {co32, s32};
            check(r1 == r0 + 33'd1, "R2", r1, r0 + 33'd1);
            drive32(y, x, 1'b1);
            check({co32, s32} == r1, "R5", {co32, s32}, r1);
        end

        // R1/R8: exhaustive 8-bit sweep, both sizing modes
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [8:0] e8;
                    a8 = i[7:0]; b8 = j[7:0]; c8 = c[0];
                    #1;
                    e8 = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
                    check({co8g, s8g} == e8, "R1", {24'd0, co8g, s8g}, {24'd0, e8});
                    check({co8u, s8u} == {co8g, s8g}, "R8",
                          {24'd0, co8u, s8u}, {24'd0, co8g, s8g});
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule